// File: doc/BRIEF.md
# Byte Prefetch Queue with Activity Status

This block sits between a word-wide memory fetch path and a byte-consuming execution side. It fetches code ahead of execution, one 16-bit word at a time, and holds the fetched bytes in a small ring buffer. In most cycles the execution side then finds its next byte already waiting. The block keeps its own 20-bit fetch pointer. Each word fetch occupies a fixed number of clock cycles. The word on `memWord` is captured in the last of those cycles.

The execution side takes bytes one at a time. With each byte it states whether that byte starts an opcode. When it needs the bus for an operand, it raises `operandHold`, and no new fetch starts while the hold is high. A jump request does three things: it discards the buffered bytes, it aborts any fetch in flight, and it moves the fetch pointer to the target address.

A registered 2-bit status code reports what the queue did in the previous cycle. The codes are: nothing, first opcode byte taken, queue flushed, or later byte taken.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is active and on the first cycle after it, `qEmpty` is 1, `fetchBusy` is 0 and `qStatus` is 00.
- R2: A word fetch starts only when all three hold: no fetch is in flight, no jump is requested, and at least 2 of the DEPTH (6) byte slots are free. `fetchBusy` is then high for exactly FETCH_CYCLES (4) consecutive cycles, and the word is written at the end of the last of them.
- R3: `fetchAddr` is the word-aligned fetch pointer (bit 0 reads 0). After a jump, the first fetch uses the target with bit 0 cleared, and each completed fetch adds 2.
- R4: Bytes leave the queue in ascending address order. Within a word, the low byte `memWord[7:0]` belongs to the even address and the high byte `memWord[15:8]` to the odd address.
- R5: When the jump target is odd, only `memWord[15:8]` of the first fetched word is queued, so the first byte popped is the byte at the target address.
- R6: Occupancy never exceeds DEPTH. If nothing is popped after a jump, the queue settles at 6 bytes for an even target and 5 bytes for an odd target.
- R7: While `operandHold` is 1, no new fetch starts. A fetch already in flight still completes, and prefetching resumes once the hold drops.
- R8: A jump empties the queue. On the next cycle `qEmpty` is 1 and `qStatus` is 10.
- R9: A jump and a pop in the same cycle resolve as a flush. The status is 10 and the byte that was offered is not consumed.
- R10: `qByte` shows the head byte without waiting for a clock edge. A pop from a non-empty queue consumes that byte. On the next cycle `qStatus` is 01 if `popFirst` was 1, and 11 if it was 0.
- R11: `qEmpty` reflects the current occupancy combinationally. A pop while the queue is empty is ignored, and the next status is 00.
- R12: In a cycle with neither a pop nor a jump, the following cycle reports `qStatus` 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jumpReq | input | 1 | Flush the queue and reload the fetch pointer |
| jumpAddr | input | 20 | New fetch byte address, used with `jumpReq` |
| operandHold | input | 1 | Execution side needs the bus; blocks new fetch starts |
| popReq | input | 1 | Take the head byte |
| popFirst | input | 1 | The byte taken is the first byte of an opcode |
| memWord | input | 16 | Word read at `fetchAddr`, captured in the last fetch cycle |
| fetchBusy | output | 1 | A word fetch is in flight |
| fetchAddr | output | 20 | Word-aligned address of the current fetch |
| qEmpty | output | 1 | Queue holds no bytes |
| qByte | output | 8 | Head byte of the queue |
| qStatus | output | 2 | Previous-cycle queue activity: 00 none, 01 first byte, 10 flush, 11 later byte |

## Verification
The checker evaluates the following on every cycle:
- the status code that follows each jump, pop, ignored pop and idle cycle;
- that a flush leaves the queue empty;
- that occupancy stays within the buffer;
- that a fetch starts only with two free slots and no operand hold.

Some behaviours need the bench's scenarios and its byte-by-byte address scoreboard:
- the byte order across words and odd jump targets;
- the exact four-cycle fetch length;
- address stepping;
- the 6-byte and 5-byte fill levels;
- that an in-flight fetch completes under a hold.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef struct packed {
    logic flush;
    logic fill;
    logic pop;
  } pfqStrobes_t;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } pfqStatus_t;

endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH        = 6,
  parameter int FETCH_CYCLES = 4,
  parameter int CW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          jumpReq,
  input  logic          operandHold,
  input  logic          popReq,
  input  logic          popFirst,
  input  logic          queueEmpty,
  input  logic [CW-1:0] occupancy,
  output pfqStrobes_t   strobes,
  output logic          fetchBusy,
  output logic [1:0]    qStatus
);
  localparam int TW = (FETCH_CYCLES > 1) ? $clog2(FETCH_CYCLES) : 1;

  logic          busy;
  logic [TW-1:0] tick;
  logic [CW:0]   freeSlots;
  logic          roomForWord;
  logic          startFetch;
  logic          lastTick;
  pfqStatus_t    statusReg;

  always_comb begin
    freeSlots   = (CW + 1)'(DEPTH) - {1'b0, occupancy};
    roomForWord = freeSlots >= (CW + 1)'(2);
    startFetch  = !busy && !jumpReq && !operandHold && roomForWord;
    lastTick    = busy && (tick == TW'(FETCH_CYCLES - 1));
    strobes.flush = jumpReq;
    strobes.fill  = lastTick && !jumpReq;
    strobes.pop   = popReq && !queueEmpty && !jumpReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      tick <= '0;
    end else if (jumpReq) begin
      busy <= 1'b0;
      tick <= '0;
    end else if (startFetch) begin
      busy <= 1'b1;
      tick <= '0;
    end else if (lastTick) begin
      busy <= 1'b0;
    end else if (busy) begin
      tick <= tick + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      statusReg <= QS_IDLE;
    else if (jumpReq)
      statusReg <= QS_FLUSH;
    else if (strobes.pop)
      statusReg <= popFirst ? QS_FIRST : QS_NEXT;
    else
      statusReg <= QS_IDLE;
  end

  assign fetchBusy = busy;
  assign qStatus   = statusReg;

endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int AW    = 20,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  pfqStrobes_t   strobes,
  input  logic [AW-1:0] jumpAddr,
  input  logic [15:0]   memWord,
  output logic [7:0]    headByte,
  output logic          queueEmpty,
  output logic [CW-1:0] occupancy,
  output logic [AW-1:0] fetchAddr
);
  logic [7:0]    slots [DEPTH];
  logic [PW-1:0] headIdx;
  logic [PW-1:0] tailIdx;
  logic [CW-1:0] count;
  logic [AW-1:0] bytePtr;
  logic          oddStart;
  logic [CW-1:0] pushCount;

  function automatic logic [PW-1:0] nextIdx(input logic [PW-1:0] idx);
    return (idx == PW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    oddStart  = bytePtr[0];
    pushCount = strobes.fill ? (oddStart ? CW'(1) : CW'(2)) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
      bytePtr <= '0;
    end else if (strobes.flush) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
      bytePtr <= jumpAddr;
    end else begin
      if (strobes.pop)
        headIdx <= nextIdx(headIdx);
      if (strobes.fill) begin
        tailIdx <= oddStart ? nextIdx(tailIdx) : nextIdx(nextIdx(tailIdx));
        bytePtr <= {bytePtr[AW-1:1] + 1'b1, 1'b0};
      end
      count <= count + pushCount - CW'(strobes.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fill && !strobes.flush) begin
      if (oddStart) begin
        slots[tailIdx] <= memWord[15:8];
      end else begin
        slots[tailIdx]          <= memWord[7:0];
        slots[nextIdx(tailIdx)] <= memWord[15:8];
      end
    end
  end

  assign headByte   = slots[headIdx];
  assign queueEmpty = (count == '0);
  assign occupancy  = count;
  assign fetchAddr  = {bytePtr[AW-1:1], 1'b0};

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH        = 6,
  parameter int AW           = 20,
  parameter int FETCH_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          jumpReq,
  input  logic [AW-1:0] jumpAddr,
  input  logic          operandHold,
  input  logic          popReq,
  input  logic          popFirst,
  input  logic [15:0]   memWord,
  output logic          fetchBusy,
  output logic [AW-1:0] fetchAddr,
  output logic          qEmpty,
  output logic [7:0]    qByte,
  output logic [1:0]    qStatus
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  pfqStrobes_t   strobes;
  logic [CW-1:0] occupancy;

  pfq_ctrl #(.DEPTH(DEPTH), .FETCH_CYCLES(FETCH_CYCLES), .CW(CW)) ctrl (
    .clk(clk), .rstN(rstN), .jumpReq(jumpReq), .operandHold(operandHold),
    .popReq(popReq), .popFirst(popFirst), .queueEmpty(qEmpty),
    .occupancy(occupancy), .strobes(strobes), .fetchBusy(fetchBusy),
    .qStatus(qStatus)
  );

  pfq_datapath #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .PW(PW)) datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .jumpAddr(jumpAddr),
    .memWord(memWord), .headByte(qByte), .queueEmpty(qEmpty),
    .occupancy(occupancy), .fetchAddr(fetchAddr)
  );

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          jumpReq,
  input logic          operandHold,
  input logic          popReq,
  input logic          popFirst,
  input logic          qEmpty,
  input logic          fetchBusy,
  input logic [1:0]    qStatus,
  input logic [CW-1:0] occupancy
);

  assert_flush_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    jumpReq |=> qStatus == 2'b10);

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    jumpReq |=> qEmpty);

  assert_pop_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !qEmpty && !jumpReq) |=> qStatus == ($past(popFirst) ? 2'b01 : 2'b11));

  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && qEmpty && !jumpReq) |=> qStatus == 2'b00);

  assert_idle_status_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!popReq && !jumpReq) |=> qStatus == 2'b00);

  assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchBusy) |-> $past(!operandHold && !jumpReq));

  assert_room_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchBusy) |-> $past(occupancy) <= CW'(DEPTH - 2));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CW'(DEPTH));

endmodule

bind prefetch_queue pfq_checker #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rstN(rstN), .jumpReq(jumpReq), .operandHold(operandHold),
  .popReq(popReq), .popFirst(popFirst), .qEmpty(qEmpty),
  .fetchBusy(fetchBusy), .qStatus(qStatus), .occupancy(occupancy)
);

// File: tb/prefetch_queue_test.sv
`timescale 1ns/1ps
module prefetch_queue_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        jumpReq;
  logic [19:0] jumpAddr;
  logic        operandHold;
  logic        popReq;
  logic        popFirst;
  logic [15:0] memWord;
  logic        fetchBusy;
  logic [19:0] fetchAddr;
  logic        qEmpty;
  logic [7:0]  qByte;
  logic [1:0]  qStatus;

  int checks = 0;
  int errors = 0;
  logic [19:0] expAddr;
  logic [19:0] expFetch;
  logic        prevBusy;
  int          runLen;

  always #4 clk = ~clk;

  function automatic logic [7:0] byteAt(input logic [19:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ a[11:4] ^ 8'h5A;
  endfunction

  assign memWord = {byteAt(fetchAddr + 20'd1), byteAt(fetchAddr)};

  prefetch_queue uut (
    .clk(clk), .rstN(rstN), .jumpReq(jumpReq), .jumpAddr(jumpAddr),
    .operandHold(operandHold), .popReq(popReq), .popFirst(popFirst),
    .memWord(memWord), .fetchBusy(fetchBusy), .fetchAddr(fetchAddr),
    .qEmpty(qEmpty), .qByte(qByte), .qStatus(qStatus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit j, input logic [19:0] ja, input bit h, input bit p, input bit pf);
    logic [1:0] predStatus;
    bit         wasEmpty;
    bit         curBusy;
    jumpReq = j; jumpAddr = ja; operandHold = h; popReq = p; popFirst = pf;
    #1;
    wasEmpty = qEmpty;
    if (j) predStatus = 2'b10;
    else if (p && !wasEmpty) predStatus = pf ? 2'b01 : 2'b11;
    else predStatus = 2'b00;
    if (!j && p && !wasEmpty) begin
      check(qByte == byteAt(expAddr), "R4 R10 head byte", qByte, byteAt(expAddr));
      expAddr = expAddr + 20'd1;
    end
    if (j) expAddr = ja;
    @(posedge clk);
    @(negedge clk);
    if (j) begin
      check(qStatus == 2'b10, "R8 R9 flush status", qStatus, 2);
      check(qEmpty == 1'b1, "R8 empty after jump", qEmpty, 1);
    end else if (p && wasEmpty)
      check(qStatus == 2'b00, "R11 empty pop ignored", qStatus, 0);
    else if (p)
      check(qStatus == predStatus, "R10 pop status", qStatus, predStatus);
    else
      check(qStatus == 2'b00, "R12 idle status", qStatus, 0);
    curBusy = fetchBusy;
    if (curBusy && !prevBusy) begin
      check(fetchAddr == expFetch, "R3 fetch address", fetchAddr, expFetch);
      runLen = 1;
    end else if (curBusy) begin
      runLen++;
    end
    if (prevBusy && !curBusy && !j) begin
      check(runLen == 4, "R2 fetch length", runLen, 4);
      expFetch = expFetch + 20'd2;
    end
    if (j) expFetch = {ja[19:1], 1'b0};
    prevBusy = curBusy;
  endtask

  task automatic fillLevel(input logic [19:0] target, input int expLevel, input string req);
    int n = 0;
    step(1'b1, target, 1'b0, 1'b0, 1'b0);
    repeat (40) step(1'b0, 20'd0, 1'b0, 1'b0, 1'b0);
    while (!qEmpty && n < 10) begin
      step(1'b0, 20'd0, 1'b1, 1'b1, (n == 0));
      n++;
    end
    check(n == expLevel, req, n, expLevel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; jumpReq = 1'b0; jumpAddr = '0; operandHold = 1'b0;
    popReq = 1'b0; popFirst = 1'b0;
    expAddr = '0; expFetch = '0; prevBusy = 1'b0; runLen = 0;
    repeat (3) @(negedge clk);
    check(qEmpty == 1'b1, "R1 reset empty", qEmpty, 1);
    check(fetchBusy == 1'b0, "R1 reset busy", fetchBusy, 0);
    check(qStatus == 2'b00, "R1 reset status", qStatus, 0);
    rstN = 1'b1;
    step(1'b0, 20'd0, 1'b0, 1'b1, 1'b1);
    check(qEmpty == 1'b1, "R1 empty after reset", qEmpty, 1);

    // R6: even target fills to 6, R5: odd target fills to 5
    fillLevel(20'h12340, 6, "R6 even fill level");
    fillLevel(20'h0ABC5, 5, "R5 R6 odd fill level");

    // R7: hold from the jump on blocks every fetch start
    step(1'b1, 20'h40010, 1'b1, 1'b0, 1'b0);
    repeat (20) begin
      step(1'b0, 20'd0, 1'b1, 1'b0, 1'b0);
      check(fetchBusy == 1'b0, "R7 hold blocks fetch", fetchBusy, 0);
      check(qEmpty == 1'b1, "R7 nothing queued", qEmpty, 1);
    end
    step(1'b0, 20'd0, 1'b0, 1'b0, 1'b0);
    check(fetchBusy == 1'b1, "R7 fetch resumes", fetchBusy, 1);
    // R7: hold raised mid-fetch, fetch still completes
    repeat (10) step(1'b0, 20'd0, 1'b1, 1'b0, 1'b0);
    check(qEmpty == 1'b0, "R7 in-flight fetch completes", qEmpty, 0);

    // R9: jump and pop together
    step(1'b1, 20'h00777, 1'b0, 1'b1, 1'b1);
    repeat (8) step(1'b0, 20'd0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 20'd0, 1'b0, 1'b1, 1'b1);

    // R11: pop right after a jump, while empty
    step(1'b1, 20'hFFFFE, 1'b0, 1'b0, 1'b0);
    step(1'b0, 20'd0, 1'b0, 1'b1, 1'b0);

    // constrained random traffic
    void'($urandom(32'd2718));
    for (int i = 0; i < 4000; i++) begin
      bit jr = ($urandom_range(99) < 2);
      bit hd = ($urandom_range(99) < 12);
      bit pp = ($urandom_range(99) < 55);
      bit pf = $urandom_range(1);
      logic [19:0] ta = 20'($urandom());
      step(jr, ta, hd, pp, pf);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule